// File: doc/BRIEF.md
# Four-Lane Calorimeter Link Frame Aligner

The block receives four lanes of already deserialized calorimeter link words. Each lane delivers one 24-bit word per crossing with a strobe. A word holds two tower fields, each an 8-bit energy with one fine-grain flag, and a 5-bit check code. The block buffers each lane in a small queue. It releases a crossing only when every lane has a word waiting, so the words leave paired by crossing whatever the arrival skew between lanes. It checks every word, blanks the towers of a bad word, and raises that lane's region error flag.

The aligned crossing leaves over a narrower, faster path as four consecutive beats, one per lane. A marker flags the first beat. When the crossing after it is already aligned, the next crossing follows with no idle cycle. For checking data routes, a test mode replaces live traffic with a 16-entry vector store per lane. The store is loaded through a write port, and the vectors are replayed in a loop from entry 0.

Top module: `frame_aligner`

## Requirements
- R1: While reset is held and after it until the first crossing is aligned, `outValid`, `outMark` and `outErr` are 0.
- R2: In a lane word, bits [22:14] are tower A and bits [13:5] are tower B. In each tower field, bit 8 is the fine-grain flag and bits [7:0] are the energy. Bits [4:0] are the check code. For a good word, both fields appear unchanged on `outTowerA` and `outTowerB` in that lane's beat.
- R3: The check code is a CRC-5 with polynomial x^5+x^2+1 (0x05) and an initial value of 0. It is computed MSB-first over bits [22:5]. When the code does not match, that lane's beat shows both towers as 0 and `outErr` as 1.
- R4: Bit 23 is reserved. A word that has it set is treated as erroneous in the same way as a code mismatch.
- R5: Each lane queues up to four words. A crossing is released only when every lane holds at least one word. Words pair by arrival order per lane, for skews between lanes of up to three crossings.
- R6: A released crossing appears as four beats on consecutive cycles, with `outLane` 0, 1, 2, 3. `outMark` is 1 on the lane-0 beat only.
- R7: When the next crossing is aligned by the time lane 3 is presented, its lane-0 beat follows on the very next cycle.
- R8: While `testMode` is 1, live words are ignored. A crossing is produced every four cycles from vector entries 0, 1, … 15, 0, … in turn, with no gap.
- R9: A write with `vecWrEn` stores `vecWrData` at entry `vecWrAddr` of lane `vecWrChan`. Stored vectors pass through the same checks as live words (R3, R4).
- R10: Entering test mode discards all partially aligned live words. After `testMode` returns to 0, the first released crossing is made only of words received afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 4 | Per-lane word strobe |
| inWord | input | 4x24 | Per-lane link word, lane 0 in the low 24 bits |
| testMode | input | 1 | Replay stored vectors instead of live words |
| vecWrEn | input | 1 | Vector store write enable |
| vecWrChan | input | 2 | Lane selected for the vector write |
| vecWrAddr | input | 4 | Entry selected for the vector write |
| vecWrData | input | 24 | Vector word to store |
| outValid | output | 1 | A beat is presented |
| outLane | output | 2 | Lane of the presented beat |
| outTowerA | output | 9 | Tower A field of the beat (0 when erroneous) |
| outTowerB | output | 9 | Tower B field of the beat (0 when erroneous) |
| outErr | output | 1 | Region error flag for the beat's lane |
| outMark | output | 1 | First beat of a crossing |

## Verification
The aligner is driven with all lanes arriving together, with a different skew per lane inside a crossing, and with one lane held back by three whole crossings. These patterns separate correct pairing by arrival order from pairing by time of arrival. Back-to-back aligned traffic shows whether a gap cycle is ever inserted. Words are also sent with a corrupted code on selected lanes, and with only the reserved bit set, which shows that the error is confined to one region and that both towers are blanked. Test mode is run for more than sixteen crossings while live strobes keep toggling. A stale half-aligned word left from before test mode shows whether the queues are flushed on entry.

// File: rtl/fa_pkg.sv
package fa_pkg;
  parameter int NCH = 4;        // lanes
  parameter int DEPTH = 4;      // queue depth per lane (power of two)
  parameter int TW = 9;         // tower field width
  parameter int CW = 5;         // check code width
  parameter int VEC = 16;       // vector entries per lane (power of two)
  parameter logic [CW-1:0] CRC_POLY = 5'h05;

  localparam int WW = 2 * TW + CW + 1;   // lane word incl. reserved top bit
  localparam int PW = $clog2(DEPTH);
  localparam int VW = $clog2(VEC);
  localparam int LW = $clog2(NCH);

  typedef struct packed {
    logic [NCH-1:0]         push;
    logic [NCH-1:0][PW-1:0] wrPtr;
    logic [PW-1:0]          rdPtr;
    logic                   load;
    logic                   useTest;
    logic [VW-1:0]          vecIdx;
    logic                   busy;
    logic [LW-1:0]          beat;
  } ctrlStrobe_t;
endpackage

// File: rtl/fa_ctrl.sv
module fa_ctrl
  import fa_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [NCH-1:0]  inValid,
  input  logic            testMode,
  output ctrlStrobe_t     st
);
  logic [NCH-1:0][PW:0]   cnt;
  logic [NCH-1:0][PW-1:0] wrPtr;
  logic [PW-1:0]          rdPtr;
  logic                   busy;
  logic [LW-1:0]          beat;
  logic [VW-1:0]          vecIdx;

  logic                   canLoad, allReady, liveLoad, testLoad;
  logic [NCH-1:0]         push, ready;

  always_comb begin
    canLoad = !busy || (beat == LW'(NCH - 1));
    for (int c = 0; c < NCH; c++) begin
      ready[c] = (cnt[c] != '0);
      push[c]  = inValid[c] && !testMode && (cnt[c] != (PW+1)'(DEPTH));
    end
    allReady = &ready;
    liveLoad = !testMode && allReady && canLoad;
    testLoad = testMode && canLoad;
  end

  // lane queue occupancy and write pointers; flushed while in test mode
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      wrPtr <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (testMode) begin
          cnt[c]   <= '0;
          wrPtr[c] <= rdPtr;
        end else begin
          cnt[c] <= cnt[c] + (PW+1)'(push[c]) - (PW+1)'(liveLoad);
          if (push[c]) wrPtr[c] <= wrPtr[c] + 1'b1;
        end
      end
    end
  end

  // shared read pointer, beat sequencer, vector index
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr  <= '0;
      busy   <= 1'b0;
      beat   <= '0;
      vecIdx <= '0;
    end else begin
      if (liveLoad) rdPtr <= rdPtr + 1'b1;
      if (liveLoad || testLoad) begin
        busy <= 1'b1;
        beat <= '0;
      end else if (busy) begin
        if (beat == LW'(NCH - 1)) busy <= 1'b0;
        beat <= beat + 1'b1;
      end
      if (!testMode)     vecIdx <= '0;
      else if (testLoad) vecIdx <= vecIdx + 1'b1;
    end
  end

  always_comb begin
    st.push    = push;
    st.wrPtr   = wrPtr;
    st.rdPtr   = rdPtr;
    st.load    = liveLoad || testLoad;
    st.useTest = testMode;
    st.vecIdx  = vecIdx;
    st.busy    = busy;
    st.beat    = beat;
  end
endmodule

// File: rtl/fa_datapath.sv
module fa_datapath
  import fa_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobe_t             st,
  input  logic [NCH-1:0][WW-1:0]  inWord,
  input  logic                    vecWrEn,
  input  logic [LW-1:0]           vecWrChan,
  input  logic [VW-1:0]           vecWrAddr,
  input  logic [WW-1:0]           vecWrData,
  output logic                    outValid,
  output logic [LW-1:0]           outLane,
  output logic [TW-1:0]           outTowerA,
  output logic [TW-1:0]           outTowerB,
  output logic                    outErr,
  output logic                    outMark
);
  localparam int DW = 2 * TW;

  function automatic logic [CW-1:0] crcCalc(input logic [DW-1:0] d);
    logic [CW-1:0] r;
    logic fb;
    r = '0;
    for (int i = DW - 1; i >= 0; i--) begin
      fb = d[i] ^ r[CW-1];
      r  = {r[CW-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

  logic [NCH-1:0][TW-1:0] nextA, nextB, holdA, holdB;
  logic [NCH-1:0]         nextErr, holdErr;

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    logic [WW-1:0] fifoMem [DEPTH];
    logic [WW-1:0] vecMem  [VEC];
    logic [WW-1:0] srcWord;
    logic [DW-1:0] payload;
    logic          bad;

    always_ff @(posedge clk) begin
      if (st.push[c]) fifoMem[st.wrPtr[c]] <= inWord[c];
      if (vecWrEn && (vecWrChan == LW'(c))) vecMem[vecWrAddr] <= vecWrData;
    end

    assign srcWord    = st.useTest ? vecMem[st.vecIdx] : fifoMem[st.rdPtr];
    assign payload    = srcWord[WW-2 -: DW];
    assign bad        = srcWord[WW-1] || (crcCalc(payload) != srcWord[CW-1:0]);
    assign nextA[c]   = bad ? '0 : payload[DW-1:TW];
    assign nextB[c]   = bad ? '0 : payload[TW-1:0];
    assign nextErr[c] = bad;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdA   <= '0;
      holdB   <= '0;
      holdErr <= '0;
    end else if (st.load) begin
      holdA   <= nextA;
      holdB   <= nextB;
      holdErr <= nextErr;
    end
  end

  always_comb begin
    outValid  = st.busy;
    outLane   = st.beat;
    outMark   = st.busy && (st.beat == '0);
    outTowerA = st.busy ? holdA[st.beat] : '0;
    outTowerB = st.busy ? holdB[st.beat] : '0;
    outErr    = st.busy && holdErr[st.beat];
  end
endmodule

// File: rtl/frame_aligner.sv
module frame_aligner
  import fa_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NCH-1:0]          inValid,
  input  logic [NCH-1:0][WW-1:0]  inWord,
  input  logic                    testMode,
  input  logic                    vecWrEn,
  input  logic [LW-1:0]           vecWrChan,
  input  logic [VW-1:0]           vecWrAddr,
  input  logic [WW-1:0]           vecWrData,
  output logic                    outValid,
  output logic [LW-1:0]           outLane,
  output logic [TW-1:0]           outTowerA,
  output logic [TW-1:0]           outTowerB,
  output logic                    outErr,
  output logic                    outMark
);
  ctrlStrobe_t st;

  fa_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .testMode (testMode),
    .st       (st)
  );

  fa_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .inWord    (inWord),
    .vecWrEn   (vecWrEn),
    .vecWrChan (vecWrChan),
    .vecWrAddr (vecWrAddr),
    .vecWrData (vecWrData),
    .outValid  (outValid),
    .outLane   (outLane),
    .outTowerA (outTowerA),
    .outTowerB (outTowerB),
    .outErr    (outErr),
    .outMark   (outMark)
  );
endmodule

// File: rtl/fa_checker.sv
module fa_checker
  import fa_pkg::*;
(
  input logic          clk,
  input logic          rstN,
  input logic          testMode,
  input logic          outValid,
  input logic [LW-1:0] outLane,
  input logic [TW-1:0] outTowerA,
  input logic [TW-1:0] outTowerB,
  input logic          outErr,
  input logic          outMark
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!outMark && !outErr));

  // R6
  mark_lane0_chk: assert property (@(posedge clk) disable iff (!rstN)
    outMark |-> (outValid && outLane == '0));

  // R6
  lane_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outLane != LW'(NCH - 1)) |=>
      (outValid && outLane == $past(outLane) + 1'b1));

  // R3
  err_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    outErr |-> (outTowerA == '0 && outTowerB == '0));

  // R8
  test_stream_chk: assert property (@(posedge clk) disable iff (!rstN)
    (testMode && outValid && outLane == LW'(NCH - 1)) |=> outMark);
endmodule

bind frame_aligner fa_checker i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .testMode  (testMode),
  .outValid  (outValid),
  .outLane   (outLane),
  .outTowerA (outTowerA),
  .outTowerB (outTowerB),
  .outErr    (outErr),
  .outMark   (outMark)
);

// File: tb/test_frame_aligner.sv
module test_frame_aligner;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] inValid = '0;
  logic [3:0][23:0] inWord = '0;
  logic testMode = 1'b0;
  logic vecWrEn = 1'b0;
  logic [1:0] vecWrChan = '0;
  logic [3:0] vecWrAddr = '0;
  logic [23:0] vecWrData = '0;
  logic outValid, outErr, outMark;
  logic [1:0] outLane;
  logic [8:0] outTowerA, outTowerB;

  frame_aligner i_frame_aligner (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWord(inWord),
    .testMode(testMode), .vecWrEn(vecWrEn), .vecWrChan(vecWrChan),
    .vecWrAddr(vecWrAddr), .vecWrData(vecWrData), .outValid(outValid),
    .outLane(outLane), .outTowerA(outTowerA), .outTowerB(outTowerB),
    .outErr(outErr), .outMark(outMark)
  );

  always #5 clk = ~clk;  // 100 MHz

  typedef struct {
    logic [1:0] lane;
    logic [8:0] a;
    logic [8:0] b;
    logic       err;
    logic       mark;
    bit         follows;
    string      req;
  } beat_t;

  beat_t expQ[$];
  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  int lastCyc = -10;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [4:0] refCrc(input logic [17:0] d);
    logic [4:0] r;
    logic top;
    r = 5'd0;
    for (int i = 0; i < 18; i++) begin
      top = r[4] ^ d[17 - i];
      r = {r[3:0], 1'b0} ^ (top ? 5'b00101 : 5'b00000);
    end
    return r;
  endfunction

  // word layout per R2/R3/R4: {reserved, towerA[8:0], towerB[8:0], crc[4:0]}
  function automatic logic [23:0] mkWord(input logic [8:0] a, input logic [8:0] b,
                                         input bit badCrc, input bit resv);
    logic [4:0] k;
    k = refCrc({a, b});
    if (badCrc) k = k ^ 5'b01000;
    return {resv, a, b, k};
  endfunction

  function automatic logic [23:0] vecWord(input int c, input int i);
    return mkWord(9'((c * 37 + i * 11 + 5) & 'h1ff), 9'((c * 53 + i * 29 + 100) & 'h1ff),
                  (c == 2 && i == 5), 1'b0);
  endfunction

  task automatic expectCrossing(input logic [3:0][23:0] w, input bit follows0, input string req);
    for (int c = 0; c < 4; c++) begin
      beat_t e;
      logic bad;
      bad = w[c][23] || (refCrc(w[c][22:5]) != w[c][4:0]);
      e.lane = 2'(c);
      e.a = bad ? 9'd0 : w[c][22:14];
      e.b = bad ? 9'd0 : w[c][13:5];
      e.err = bad;
      e.mark = (c == 0);
      e.follows = (c != 0) || follows0;
      e.req = req;
      expQ.push_back(e);
    end
  endtask

  // driver: one crossing over four cycles, lane c strobed at offset sk[c]
  task automatic sendCrossing(input logic [3:0][23:0] w, input int sk[4],
                              input bit follows0, input string req);
    expectCrossing(w, follows0, req);
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      for (int c = 0; c < 4; c++) begin
        inValid[c] = (sk[c] == t);
        inWord[c] = w[c];
      end
    end
  endtask

  task automatic driveRaw(input logic [3:0] mask, input logic [3:0][23:0] w);
    @(negedge clk);
    inValid = mask;
    inWord = w;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = '0;
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: compare every presented beat with the scoreboard
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R8/R10", "unexpected beat lane", int'(outLane), -1);
      end else begin
        beat_t e;
        e = expQ.pop_front();
        check(outLane == e.lane, e.req, "lane", outLane, e.lane);
        check(outTowerA == e.a, e.req, "towerA", outTowerA, e.a);
        check(outTowerB == e.b, e.req, "towerB", outTowerB, e.b);
        check(outErr == e.err, e.req, "err", outErr, e.err);
        check(outMark == e.mark, e.req, "R6 mark", outMark, e.mark);
        if (e.follows)
          check(cyc == lastCyc + 1, e.req, "R7 contiguous beat cycle", cyc, lastCyc + 1);
      end
      lastCyc = cyc;
    end
  end

  task automatic runAll();
    logic [3:0][23:0] w, x0, x1, x2;
    int skA[4];
    // R1: quiet during and right after reset
    repeat (3) @(negedge clk);
    check(!outValid && !outMark && !outErr, "R1", "outputs in reset",
          {outValid, outMark, outErr}, 0);
    rstN = 1'b1;
    idle(2);
    check(!outValid && !outMark && !outErr, "R1", "outputs after reset",
          {outValid, outMark, outErr}, 0);

    // R2, R7: aligned lanes, back to back
    skA = '{0, 0, 0, 0};
    for (int k = 0; k < 4; k++) begin
      for (int c = 0; c < 4; c++)
        w[c] = mkWord(9'((k * 97 + c * 61 + 3) & 'h1ff), 9'((k * 41 + c * 150 + 256) & 'h1ff), 0, 0);
      sendCrossing(w, skA, (k != 0), "R2");
    end
    idle(8);

    // R5: skew within a crossing
    for (int k = 0; k < 3; k++) begin
      for (int c = 0; c < 4; c++)
        w[c] = mkWord(9'((k * 19 + c * 77 + 9) & 'h1ff), 9'((k * 83 + c * 13 + 400) & 'h1ff), 0, 0);
      skA = '{(k + 3) % 4, k % 4, (k + 1) % 4, 3};
      sendCrossing(w, skA, 0, "R5");
    end
    idle(8);

    // R5: lane 3 lags three whole crossings
    for (int c = 0; c < 4; c++) begin
      x0[c] = mkWord(9'(10 + c), 9'(300 + c), 0, 0);
      x1[c] = mkWord(9'(20 + c), 9'(310 + c), 0, 0);
      x2[c] = mkWord(9'(30 + c), 9'(320 + c), 0, 0);
    end
    expectCrossing(x0, 0, "R5 lag");
    expectCrossing(x1, 0, "R5 lag");
    expectCrossing(x2, 0, "R5 lag");
    driveRaw(4'b0111, x0);
    driveRaw(4'b0111, x1);
    driveRaw(4'b0111, x2);
    driveRaw(4'b1000, x0);
    idle(3);
    driveRaw(4'b1000, x1);
    idle(3);
    driveRaw(4'b1000, x2);
    idle(8);

    // R3, R4: corrupted code and reserved bit confined to their regions
    skA = '{0, 0, 0, 0};
    w[0] = mkWord(9'h1ff, 9'h0ff, 0, 0);
    w[1] = mkWord(9'h155, 9'h0aa, 1, 0);
    w[2] = mkWord(9'h012, 9'h134, 0, 0);
    w[3] = mkWord(9'h0f0, 9'h10f, 1, 0);
    sendCrossing(w, skA, 0, "R3");
    w[0] = mkWord(9'h0c3, 9'h13c, 0, 1);
    w[1] = mkWord(9'h001, 9'h100, 0, 0);
    w[2] = mkWord(9'h1a5, 9'h05a, 0, 1);
    w[3] = mkWord(9'h000, 9'h000, 0, 0);
    sendCrossing(w, skA, 1, "R4");
    idle(8);

    // R9: load vector store
    for (int c = 0; c < 4; c++)
      for (int i = 0; i < 16; i++) begin
        @(negedge clk);
        vecWrEn = 1'b1;
        vecWrChan = 2'(c);
        vecWrAddr = 4'(i);
        vecWrData = vecWord(c, i);
      end
    @(negedge clk);
    vecWrEn = 1'b0;

    // R10: leave a stale half-aligned word on lane 0
    driveRaw(4'b0001, x2);
    idle(4);
    check(!outValid, "R5", "no release with lanes missing", outValid, 0);

    // R8, R9: 18 replayed crossings while live strobes toggle
    for (int k = 0; k < 18; k++) begin
      for (int c = 0; c < 4; c++) w[c] = vecWord(c, k % 16);
      expectCrossing(w, (k != 0), (k % 16 == 5) ? "R9" : "R8");
    end
    @(negedge clk);
    testMode = 1'b1;
    inValid = 4'hf;
    inWord = x1;
    for (int t = 0; t < 72; t++) begin
      @(negedge clk);
      inValid = 4'(t);
    end
    testMode = 1'b0;
    inValid = '0;
    idle(6);

    // R10: first live crossing after test mode uses only new words
    for (int c = 0; c < 4; c++) w[c] = mkWord(9'(200 + c), 9'(50 + c), 0, 0);
    skA = '{0, 1, 2, 3};
    sendCrossing(w, skA, 0, "R10");
    idle(10);
    check(expQ.size() == 0, "R5", "scoreboard drained", expQ.size(), 0);
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (20000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule